// File: doc/BRIEF.md
# Mode-programmable byte port with service request

This block is a parallel byte port whose direction is fixed by a static `mode` pin. With `mode` = 0 it is an input port. A peripheral pulses `stb` to load a byte into the port's register. The port then lowers `srq` to tell the host that data is waiting, and the host reads the byte through a bus driver that is enabled only while both selects are active. With `mode` = 1 it is an output port. The host writes a byte by pulsing `stb` while the port is selected, and the byte is driven to the peripheral at all times. `srq` rises when the host deselects the port, telling the peripheral that new data is present.

The tri-state driver is modelled as a data vector `dout` plus an enable `dout_oe`. Every control input and the data byte are taken into the `clk` domain through two sampling flops, and all behaviour is defined on those sampled values. While the sampled strobe is high and a write is allowed, the register is transparent: `dout` shows the sampled data directly. When the strobe falls, the last sampled byte is held.

Top module: `byte_port_srq`

## Requirements
- R1: `stb`, `sel_a`, `sel_b`, `clr` and `din` each pass through two sampling flops. A change on one of them shows on `dout`/`dout_oe` after two rising edges of `clk` and on `srq` after three.
- R2: With `mode` = 0, `dout` follows the sampled `din` while the sampled `stb` is high. When the sampled `stb` falls, the last byte is held in the register and stays on `dout` until the next strobe or clear.
- R3: With `mode` = 0, `dout_oe` is 1 exactly when the sampled `sel_a` and sampled `sel_b` are both 1, and 0 for the other three combinations.
- R4: With `mode` = 0, a falling edge of the sampled `stb` drives `srq` to 0. `srq` returns to 1 on the cycle in which the selection (both selects high) ends.
- R5: With `mode` = 0, any cycle with both sampled selects high forces `srq` to 0, with or without a strobe. When a strobe falling edge and the end of selection occur in the same cycle, `srq` stays at 0.
- R6: With `mode` = 1, `dout_oe` is always 1. A write takes place only while sampled `sel_a` = 0, sampled `sel_b` = 1 and sampled `stb` = 1. During the write, `dout` is transparent to the sampled `din`; afterwards it holds. A strobe while the port is not selected leaves `dout` unchanged.
- R7: With `mode` = 1, `srq` goes to 1 on the cycle in which the port leaves the selected state (`sel_a` = 0, `sel_b` = 1) and returns to 0 at the next falling edge of the sampled `stb`. If both happen in the same cycle, `srq` is 1.
- R8: While the sampled `clr` is 1, `dout` is 0, the register is set to 0, and `srq` is driven to 1 (`mode` = 0) or to 0 (`mode` = 1). This overrides any strobe or select event in the same cycle. After clear, `dout` shows 0 until a new write.
- R9: During and right after reset, `dout` = 0 and `srq` has its cleared value from R8. `dout_oe` is 0 with `mode` = 0 and 1 with `mode` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | Static direction: 0 input port, 1 output port |
| stb | input | 1 | Strobe; the register is transparent while it is high |
| sel_a | input | 1 | Select A (active high in input mode, active low in output mode) |
| sel_b | input | 1 | Select B, active high |
| clr | input | 1 | Clear, active high |
| din | input | W | Data byte into the register |
| dout | output | W | Register view (transparent during a write) |
| dout_oe | output | 1 | Output driver enable |
| srq | output | 1 | Service request; its polarity depends on `mode` |

## Verification
The hardest situations to reach from the pins are coincident events: a strobe falling edge that lands in the same sampled cycle as the end of selection, and a clear that arrives while a strobe and a select are active. Every control input goes through sampling flops of equal length, so the bench creates these cases by changing the relevant pins after the same clock edge. A behavioural model, driven by a queue of pin history, predicts every cycle, including the precedence between the events. A one-cycle select pulse with no strobe reaches the input-mode case in which selection alone raises the request.

// File: rtl/byte_port_srq.sv
module byte_port_srq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode,
  input  logic         stb,
  input  logic         sel_a,
  input  logic         sel_b,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_oe,
  output logic         srq
);
  localparam int NC = 4;

  logic [NC-1:0] c1, c2;
  logic [W-1:0]  d1, d2, regv;
  logic          stb_q, sel_q, flag, flag_nx;
  logic          clr_s, stb_s, sa_s, sb_s, sel_now, wr, fall, leave;

  assign clr_s   = c2[3];
  assign stb_s   = c2[2];
  assign sa_s    = c2[1];
  assign sb_s    = c2[0];
  assign sel_now = mode ? (~sa_s & sb_s) : (sa_s & sb_s);
  assign wr      = ~clr_s & stb_s & (~mode | sel_now);
  assign fall    = stb_q & ~stb_s;
  assign leave   = sel_q & ~sel_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1    <= '0;
      c2    <= '0;
      d1    <= '0;
      d2    <= '0;
      stb_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      c1    <= {clr, stb, sel_a, sel_b};
      c2    <= c1;
      d1    <= din;
      d2    <= d1;
      stb_q <= stb_s;
      sel_q <= sel_now;
    end
  end

  always_comb begin
    flag_nx = flag;
    if (clr_s)
      flag_nx = 1'b0;
    else if (!mode) begin
      if (sel_now || fall) flag_nx = 1'b1;
      else if (leave)      flag_nx = 1'b0;
    end else begin
      if (leave)     flag_nx = 1'b1;
      else if (fall) flag_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regv <= '0;
      flag <= 1'b0;
    end else begin
      flag <= flag_nx;
      if (clr_s)   regv <= '0;
      else if (wr) regv <= d2;
    end
  end

  assign dout    = clr_s ? '0 : (wr ? d2 : regv);
  assign dout_oe = mode | sel_now;
  assign srq     = mode ? flag : ~flag;
endmodule

module byte_port_srq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode,
  input logic         clr_s,
  input logic         stb_s,
  input logic         stb_q,
  input logic         sa_s,
  input logic         sb_s,
  input logic         sel_q,
  input logic         sel_now,
  input logic [W-1:0] regv,
  input logic         flag,
  input logic         srq,
  input logic         dout_oe
);
  // R8
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (regv == '0 && flag == 1'b0));

  // R2
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !clr_s && !stb_s) |=> $stable(regv));

  // R4
  in_fall_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !clr_s && stb_q && !stb_s) |=> !srq);

  // R5
  in_select_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !clr_s && sa_s && sb_s) |=> !srq);

  // R6
  out_nowrite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !clr_s && !(!sa_s && sb_s && stb_s)) |=> $stable(regv));

  // R6
  out_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> dout_oe);

  // R7
  out_leave_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !clr_s && sel_q && !sel_now) |=> srq);
endmodule

bind byte_port_srq byte_port_srq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .clr_s(clr_s), .stb_s(stb_s),
  .stb_q(stb_q), .sa_s(sa_s), .sb_s(sb_s), .sel_q(sel_q), .sel_now(sel_now),
  .regv(regv), .flag(flag), .srq(srq), .dout_oe(dout_oe)
);

// File: tb/byte_port_srq_bench.sv
module byte_port_srq_bench;
  logic       clk = 1'b0;
  logic       rst_n, mode, stb, sel_a, sel_b, clr;
  logic [7:0] din, dout;
  logic       dout_oe, srq;
  int         compared = 0, mismatched = 0;
  string      phase = "R9";
  bit         done = 1'b0;

  always #2 clk = ~clk;

  byte_port_srq #(.W(8)) u_byte_port_srq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .stb(stb), .sel_a(sel_a),
    .sel_b(sel_b), .clr(clr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .srq(srq)
  );

  // pin history: [11] clear, [10] strobe, [9] select A, [8] select B, [7:0] data
  logic [11:0] hist[$];
  logic [7:0]  m_byte;
  bit          m_req;

  function automatic bit picked(input bit md, input logic [11:0] s);
    return md ? (!s[9] && s[8]) : (s[9] && s[8]);
  endfunction

  initial begin
    hist = '{12'h0, 12'h0, 12'h0, 12'h0};
    m_byte = 8'h00;
    m_req = 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{12'h0, 12'h0, 12'h0, 12'h0};
      m_byte = 8'h00;
      m_req = 1'b0;
    end else begin
      logic [11:0] now_s, was_s;
      now_s = hist[1];
      was_s = hist[2];
      if (now_s[11]) begin
        m_byte = 8'h00;
        m_req = 1'b0;
      end else begin
        if (now_s[10] && (!mode || picked(mode, now_s))) m_byte = now_s[7:0];
        if (!mode) begin
          if (picked(mode, now_s)) m_req = 1'b1;
          else if (was_s[10] && !now_s[10]) m_req = 1'b1;
          else if (picked(mode, was_s)) m_req = 1'b0;
        end else begin
          if (picked(mode, was_s) && !picked(mode, now_s)) m_req = 1'b1;
          else if (was_s[10] && !now_s[10]) m_req = 1'b0;
        end
      end
      hist.push_front({clr, stb, sel_a, sel_b, din});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    logic [11:0] s;
    logic [7:0]  e_dout;
    bit          e_oe, e_srq;
    if (!done) begin
      s = hist[1];
      if (s[11]) e_dout = 8'h00;
      else if (s[10] && (!mode || picked(mode, s))) e_dout = s[7:0];
      else e_dout = m_byte;
      e_oe = mode ? 1'b1 : picked(mode, s);
      e_srq = mode ? m_req : !m_req;
      compared++;
      if (dout !== e_dout || dout_oe !== e_oe || srq !== e_srq) begin
        mismatched++;
        $display("FAIL %s t=%0t dout=%h/%h oe=%b/%b srq=%b/%b (actual/expected)",
                 phase, $time, dout, e_dout, dout_oe, e_oe, srq, e_srq);
      end
    end
  end

  task automatic drv(input bit c, input bit s, input bit a, input bit b,
                     input logic [7:0] d, input int n);
    clr = c; stb = s; sel_a = a; sel_b = b; din = d;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset(input bit md);
    phase = "R9";
    rst_n = 1'b0;
    mode = md;
    drv(0, 0, md, !md, 8'h00, 4);
    rst_n = 1'b1;
    drv(0, 0, md, !md, 8'h00, 3);
  endtask

  initial begin
    rst_n = 1'b0; mode = 1'b0;
    clr = 0; stb = 0; sel_a = 0; sel_b = 0; din = 8'h00;
    do_reset(1'b0);
    phase = "R1";
    drv(0, 1, 0, 0, 8'hA5, 1);
    drv(0, 0, 0, 0, 8'h5A, 5);
    phase = "R2";
    drv(0, 1, 0, 0, 8'h11, 1);
    drv(0, 1, 0, 0, 8'h22, 1);
    drv(0, 1, 0, 0, 8'h33, 2);
    drv(0, 0, 0, 0, 8'hEE, 4);
    phase = "R3";
    drv(0, 0, 1, 0, 8'hEE, 3);
    drv(0, 0, 0, 1, 8'hEE, 3);
    drv(0, 0, 1, 1, 8'hEE, 3);
    drv(0, 0, 0, 0, 8'hEE, 4);
    phase = "R4";
    drv(0, 1, 0, 0, 8'h6C, 2);
    drv(0, 0, 0, 0, 8'h00, 4);
    drv(0, 0, 1, 1, 8'h00, 3);
    drv(0, 0, 1, 0, 8'h00, 4);
    phase = "R5";
    drv(0, 0, 1, 1, 8'h00, 1);
    drv(0, 0, 0, 1, 8'h00, 5);
    drv(0, 1, 1, 1, 8'h9D, 3);
    drv(0, 0, 0, 1, 8'h00, 5);
    drv(0, 0, 1, 1, 8'h00, 2);
    drv(0, 0, 0, 0, 8'h00, 4);
    phase = "R8";
    drv(0, 1, 1, 1, 8'hC3, 2);
    drv(1, 1, 1, 1, 8'h3C, 2);
    drv(0, 1, 1, 1, 8'h77, 2);
    drv(1, 0, 0, 0, 8'h00, 1);
    drv(0, 0, 0, 0, 8'h00, 5);

    do_reset(1'b1);
    phase = "R6";
    drv(0, 1, 0, 1, 8'h4B, 1);
    drv(0, 1, 0, 1, 8'hB4, 2);
    drv(0, 0, 0, 1, 8'hFF, 4);
    drv(0, 1, 1, 1, 8'h12, 3);
    drv(0, 1, 0, 0, 8'h34, 3);
    drv(0, 0, 1, 0, 8'h00, 4);
    phase = "R7";
    drv(0, 0, 0, 1, 8'h00, 3);
    drv(0, 0, 1, 1, 8'h00, 4);
    drv(0, 1, 1, 0, 8'h00, 2);
    drv(0, 0, 1, 0, 8'h00, 4);
    drv(0, 1, 0, 1, 8'h81, 2);
    drv(0, 0, 1, 1, 8'h00, 5);
    phase = "R8";
    drv(0, 1, 0, 1, 8'hD2, 2);
    drv(1, 1, 0, 1, 8'h2D, 2);
    drv(1, 0, 1, 0, 8'h00, 2);
    drv(0, 0, 1, 0, 8'h00, 5);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog %s expired", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule